// File: doc/BRIEF.md
# Four-Digit Multiplexed Seven-Segment Display Driver

This block is the only driver of a four-digit, time-multiplexed seven-segment display. A two-bit mode input selects what appears: a fixed "Hi" greeting, the four BCD digits of a running timer (shown as m.ss.t), an animated single segment that runs around the outer ring of every digit, or a dark display. Every source of content feeds one internal multiplexer, so each display wire has exactly one driver.

A free-running refresh counter sweeps the four digits. Its two most significant bits pick the digit being lit. A separate animation step advances each time the counter wraps. All display outputs are active-low and are registered. The surrounding logic only needs to change the mode and supply the timer digits.

Top module: `seg_scan_driver`

## Requirements
- R1: A synchronous active-high `rst` clears the refresh counter and the animation step. It also drives all outputs inactive on the next edge: `seg_n` = 1111111, `dp_n` = 1 and `dig_en_n` = 1111. The first scan slot after release is digit 0.
- R2: In modes 0, 1 and 2, the digit slot is the top two bits of a free-running REFRESH_W-bit counter. Slots 0, 1, 2 and 3 give `dig_en_n` = 1110, 1101, 1011 and 0111. Digit 0 is the rightmost.
- R3: All outputs are registered. The value visible after an edge is computed from the counter, step, mode and digits held before that edge. A mode change therefore shows on the very next output update.
- R4: In mode 1, digit k shows `timer_bcd[4k+3:4k]`. `seg_n` is ordered {g,f,e,d,c,b,a}, and the values 0 to 9 map to 1000000, 1111001, 0100100, 0110000, 0011001, 0010010, 0000010, 1111000, 0000000 and 0010000.
- R5: In mode 1, a nibble from 10 to 15 is shown as a dash, 0111111.
- R6: In mode 1, `dp_n` is 0 while digit 1 or digit 3 is enabled, and 1 while digit 0 or digit 2 is enabled.
- R7: In mode 0, digit 1 shows H (0001001) and digit 0 shows i (1111011). Digits 2 and 3 show 1111111, and `dp_n` is 1.
- R8: In mode 2, every digit shows one lit segment selected by the step. Steps 0 to 5 light a, b, c, d, e and f, which is `seg_n` = ~(1 << step). `dp_n` is 1.
- R9: The step holds except on the cycle where the refresh counter is all ones. On that cycle it advances, and it wraps from 5 back to 0.
- R10: In mode 3, `seg_n` = 1111111, `dp_n` = 1 and `dig_en_n` = 1111. The counter and step keep running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_mode | input | 2 | 0 greeting, 1 timer, 2 animation, 3 dark |
| timer_bcd | input | 16 | Four BCD digits, digit 0 in bits 3:0 |
| seg_n | output | 7 | Active-low segments {g,f,e,d,c,b,a} |
| dp_n | output | 1 | Active-low decimal point |
| dig_en_n | output | 4 | Active-low digit enables |

## Verification
The bench switches mode every few cycles, including in the middle of a scan slot. A design that used a stale mode, or latched the mode only at slot boundaries, would show the wrong content for a few cycles. Timer digits include nibbles 10 to 15, which a design without the dash fallback would show as garbage. The bench runs the animation through several counter wraps to catch an off-by-one wrap or a step that never returns from f to a. It also applies a reset in the middle of a run, which exposes a counter or step that is not cleared. The bench further checks that the decimal point is lit only on odd digits and that mode 3 turns every enable off.

// File: rtl/seg_disp_pkg.sv
package seg_disp_pkg;

  typedef enum logic [1:0] {
    MODE_HI    = 2'd0,
    MODE_TIMER = 2'd1,
    MODE_DANCE = 2'd2,
    MODE_DARK  = 2'd3
  } disp_mode_e;

  localparam logic [6:0] SEG_OFF  = 7'b1111111;
  localparam logic [6:0] SEG_DASH = 7'b0111111;
  localparam logic [6:0] GLYPH_H  = 7'b0001001;
  localparam logic [6:0] GLYPH_I  = 7'b1111011;

  // Active-low segment pattern for one BCD nibble, {g,f,e,d,c,b,a}
  function automatic logic [6:0] bcd_glyph(input logic [3:0] v);
    logic [6:0] s;
    case (v)
      4'd0:    s = 7'b1000000;
      4'd1:    s = 7'b1111001;
      4'd2:    s = 7'b0100100;
      4'd3:    s = 7'b0110000;
      4'd4:    s = 7'b0011001;
      4'd5:    s = 7'b0010010;
      4'd6:    s = 7'b0000010;
      4'd7:    s = 7'b1111000;
      4'd8:    s = 7'b0000000;
      4'd9:    s = 7'b0010000;
      default: s = SEG_DASH;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/scan_timebase.sv
module scan_timebase #(
  parameter int REFRESH_W = 18,
  parameter int SLOT_W    = 2,
  parameter int STEPS     = 6,
  parameter int STEP_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  output logic [SLOT_W-1:0] slot,
  output logic [STEP_W-1:0] step
);

  localparam logic [REFRESH_W-1:0] CNT_ONE   = REFRESH_W'(1);
  localparam logic [STEP_W-1:0]    STEP_ONE  = STEP_W'(1);
  localparam logic [STEP_W-1:0]    STEP_LAST = STEP_W'(STEPS - 1);

  logic [REFRESH_W-1:0] cnt;
  logic                 wrap;

  assign wrap = &cnt;
  assign slot = cnt[REFRESH_W-1 -: SLOT_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CNT_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step <= '0;
    end else if (wrap) begin
      step <= (step == STEP_LAST) ? '0 : step + STEP_ONE;
    end
  end

  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (rst)
    step <= STEP_LAST); // R9
  AST_STEP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wrap)) |-> $stable(step)); // R9
  AST_STEP_MOVE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wrap)) |-> (step != $past(step))); // R9

endmodule

// File: rtl/digit_glyph_bank.sv
module digit_glyph_bank #(
  parameter int NUM_DIGITS = 4
) (
  input  logic [NUM_DIGITS-1:0][3:0] bcd,
  output logic [NUM_DIGITS-1:0][6:0] glyph
);
  import seg_disp_pkg::*;

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_dig
    assign glyph[k] = bcd_glyph(bcd[k]);
  end

endmodule

// File: rtl/frame_composer.sv
module frame_composer #(
  parameter int NUM_DIGITS = 4,
  parameter int SLOT_W     = 2,
  parameter int STEP_W     = 3
) (
  input  logic [1:0]                 mode,
  input  logic [SLOT_W-1:0]          slot,
  input  logic [STEP_W-1:0]          step,
  input  logic [NUM_DIGITS-1:0][6:0] glyph,
  output logic [6:0]                 seg_n,
  output logic                       dp_n,
  output logic [NUM_DIGITS-1:0]      en_n
);
  import seg_disp_pkg::*;

  localparam logic [SLOT_W-1:0]     SLOT_I   = SLOT_W'(0);
  localparam logic [SLOT_W-1:0]     SLOT_H   = SLOT_W'(1);
  localparam logic [NUM_DIGITS-1:0] EN_ONE   = NUM_DIGITS'(1);
  localparam logic [6:0]            RING_ONE = 7'd1;

  logic [NUM_DIGITS-1:0] scan_en_n;
  logic [6:0]            hi_seg, timer_seg, dance_seg;
  logic                  timer_dp_n;

  assign scan_en_n = ~(EN_ONE << slot);

  always_comb begin
    if (slot == SLOT_H)      hi_seg = GLYPH_H;
    else if (slot == SLOT_I) hi_seg = GLYPH_I;
    else                     hi_seg = SEG_OFF;
  end

  assign timer_seg  = glyph[slot];
  assign timer_dp_n = ~slot[0];
  assign dance_seg  = ~(RING_ONE << step);

  always_comb begin
    seg_n = SEG_OFF;
    dp_n  = 1'b1;
    en_n  = scan_en_n;
    case (disp_mode_e'(mode))
      MODE_HI:    seg_n = hi_seg;
      MODE_TIMER: begin
        seg_n = timer_seg;
        dp_n  = timer_dp_n;
      end
      MODE_DANCE: seg_n = dance_seg;
      default:    en_n  = '1;
    endcase
  end

endmodule

// File: rtl/seg_scan_driver.sv
module seg_scan_driver #(
  parameter int REFRESH_W  = 18,
  parameter int NUM_DIGITS = 4,
  parameter int STEPS      = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              disp_mode,
  input  logic [4*NUM_DIGITS-1:0] timer_bcd,
  output logic [6:0]              seg_n,
  output logic                    dp_n,
  output logic [NUM_DIGITS-1:0]   dig_en_n
);
  import seg_disp_pkg::*;

  localparam int SLOT_W = $clog2(NUM_DIGITS);
  localparam int STEP_W = $clog2(STEPS);

  logic [SLOT_W-1:0]          slot;
  logic [STEP_W-1:0]          step;
  logic [NUM_DIGITS-1:0][3:0] bcd_arr;
  logic [NUM_DIGITS-1:0][6:0] glyph;
  logic [6:0]                 nxt_seg;
  logic                       nxt_dp;
  logic [NUM_DIGITS-1:0]      nxt_en;

  assign bcd_arr = timer_bcd;

  scan_timebase #(
    .REFRESH_W(REFRESH_W), .SLOT_W(SLOT_W), .STEPS(STEPS), .STEP_W(STEP_W)
  ) u_tb (
    .clk(clk), .rst(rst), .slot(slot), .step(step)
  );

  digit_glyph_bank #(.NUM_DIGITS(NUM_DIGITS)) u_glyph (
    .bcd(bcd_arr), .glyph(glyph)
  );

  frame_composer #(
    .NUM_DIGITS(NUM_DIGITS), .SLOT_W(SLOT_W), .STEP_W(STEP_W)
  ) u_comp (
    .mode(disp_mode), .slot(slot), .step(step), .glyph(glyph),
    .seg_n(nxt_seg), .dp_n(nxt_dp), .en_n(nxt_en)
  );

  // Single owner of the display pins
  always_ff @(posedge clk) begin
    if (rst) begin
      seg_n    <= SEG_OFF;
      dp_n     <= 1'b1;
      dig_en_n <= '1;
    end else begin
      seg_n    <= nxt_seg;
      dp_n     <= nxt_dp;
      dig_en_n <= nxt_en;
    end
  end

  AST_ONE_DIGIT_LIT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(disp_mode) != 2'd3) |-> $onehot(~dig_en_n)); // R2
  AST_DARK_MODE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(disp_mode) == 2'd3)
      |-> (dig_en_n == '1 && seg_n == SEG_OFF && dp_n)); // R10
  AST_DANCE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(disp_mode) == 2'd2) |-> ($countones(~seg_n) == 1 && dp_n)); // R8
  AST_TIMER_POINT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(disp_mode) == 2'd1)
      |-> (dp_n == (dig_en_n[1] & dig_en_n[3]))); // R6
  AST_HI_NO_POINT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(disp_mode) == 2'd0) |-> dp_n); // R7

endmodule

// File: tb/sim_seg_scan_driver.sv
module sim_seg_scan_driver;

  localparam int RW = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  disp_mode = 2'd0;
  logic [15:0] timer_bcd = 16'h0000;
  logic [6:0]  seg_n;
  logic        dp_n;
  logic [3:0]  dig_en_n;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  seg_scan_driver #(.REFRESH_W(RW), .NUM_DIGITS(4), .STEPS(6)) u0 (
    .clk(clk), .rst(rst), .disp_mode(disp_mode), .timer_bcd(timer_bcd),
    .seg_n(seg_n), .dp_n(dp_n), .dig_en_n(dig_en_n)
  );

  // bench model state
  logic [RW-1:0] m_cnt  = '0;
  logic [2:0]    m_step = '0;
  logic [6:0]    e_seg  = 7'h7F;
  logic          e_dp   = 1'b1;
  logic [3:0]    e_en   = 4'hF;
  string         tag_seg = "R1", tag_dp = "R1", tag_en = "R1";

  function automatic logic [6:0] ref_digit(input logic [3:0] v);
    case (v)
      4'd0: return 7'b1000000;  4'd1: return 7'b1111001;
      4'd2: return 7'b0100100;  4'd3: return 7'b0110000;
      4'd4: return 7'b0011001;  4'd5: return 7'b0010010;
      4'd6: return 7'b0000010;  4'd7: return 7'b1111000;
      4'd8: return 7'b0000000;  4'd9: return 7'b0010000;
      default: return 7'b0111111;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [6:0] act, input logic [6:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Compute what the next edge must produce, then advance the model
  task automatic predict(input logic [1:0] prev_mode);
    logic [1:0] slot;
    slot = m_cnt[RW-1:RW-2];
    if (rst) begin
      e_seg = 7'h7F; e_dp = 1'b1; e_en = 4'hF;
      tag_seg = "R1"; tag_dp = "R1"; tag_en = "R1";
      m_cnt = '0; m_step = '0;
      return;
    end
    e_en = ~(4'b0001 << slot); tag_en = "R2";
    e_dp = 1'b1;
    case (disp_mode)
      2'd0: begin
        e_seg = (slot == 2'd1) ? 7'b0001001 : (slot == 2'd0) ? 7'b1111011 : 7'h7F;
        tag_seg = "R7"; tag_dp = "R7";
      end
      2'd1: begin
        logic [3:0] nib;
        nib = timer_bcd[4*slot +: 4];
        e_seg = ref_digit(nib);
        e_dp  = ~slot[0];
        tag_seg = (nib > 4'd9) ? "R5" : "R4"; tag_dp = "R6";
      end
      2'd2: begin
        e_seg = ~(7'd1 << m_step);
        tag_seg = (m_step != 3'd0) ? "R9" : "R8"; tag_dp = "R8";
      end
      default: begin
        e_seg = 7'h7F; e_en = 4'hF;
        tag_seg = "R10"; tag_dp = "R10"; tag_en = "R10";
      end
    endcase
    if (prev_mode != disp_mode) tag_seg = "R3";
    if (&m_cnt) m_step = (m_step == 3'd5) ? 3'd0 : m_step + 3'd1;
    m_cnt = m_cnt + 1'b1;
  endtask

  logic [1:0] last_mode = 2'd0;

  // one cycle: check previous prediction, apply inputs, predict
  task automatic cycle(input logic r, input logic [1:0] m, input logic [15:0] d);
    @(negedge clk);
    chk(tag_seg, seg_n, e_seg);
    chk(tag_dp, {6'd0, dp_n}, {6'd0, e_dp});
    chk(tag_en, {3'd0, dig_en_n}, {3'd0, e_en});
    rst = r; disp_mode = m; timer_bcd = d;
    predict(last_mode);
    last_mode = m;
  endtask

  initial begin
    void'($urandom(32'd2024));
    // R1: reset holds everything dark
    repeat (4) cycle(1'b1, 2'd1, 16'h1234);
    // R7 greeting over a full scan
    repeat (70) cycle(1'b0, 2'd0, 16'h0000);
    // R4 valid readout 9.59.9 style, R6 points
    repeat (70) cycle(1'b0, 2'd1, 16'h9599);
    // R5 invalid nibbles
    repeat (70) cycle(1'b0, 2'd1, 16'hFACB);
    // R8 / R9 animation across several wraps
    repeat (450) cycle(1'b0, 2'd2, 16'h0000);
    // R10 dark
    repeat (70) cycle(1'b0, 2'd3, 16'h5555);
    // random mix with mid-run reset (R1, R3)
    for (int i = 0; i < 3000; i++) begin
      logic [1:0]  m;
      logic [15:0] d;
      m = 2'($urandom % 4);
      d = 16'($urandom);
      for (int j = 0; j < int'($urandom % 8) + 1; j++)
        cycle((i == 1500) && (j == 0), m, d);
    end
    cycle(1'b0, 2'd0, 16'h0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule